// File: doc/BRIEF.md
# Tear-Free Split-Word Counter Reader

This block fetches a 64-bit quantity that a peripheral exposes only as two 32-bit registers. The value may be counting while it is fetched. A plain low-then-high fetch can pair a low half taken before a carry with a high half taken after it. The block avoids that torn result with a three-read attempt. It reads the upper half, then the lower half, then the upper half again. It accepts the attempt only when both upper-half reads return the same word.

A start pulse loads a base address and launches the sequence. The block acts as a master on a plain 32-bit read port. It asserts a one-cycle request with an address and waits for the matching response before it issues the next read. A poll budget caps the number of attempts. If the budget runs out, the block reports a timeout with a zero result, so software can never hang on a value that never settles.

Top module: `tearfree_rd`

## Requirements
- R1: While reset is held and right after it, `busy`, `rd_req`, `done` and `timed_out` are 0 and `value` is zero.
- R2: Every attempt issues three reads in this order: address `base+4` (upper half), address `base` (lower half), then `base+4` again. The base is the address captured with the accepted start.
- R3: At most one read is in flight. After `rd_req`, no further request is issued until `rsp_vld` has returned the data.
- R4: When the two upper-half words of an attempt are equal, the block pulses `done` with `timed_out` at 0. `value` is then `{first upper word, lower word}` and stays there until the next completion.
- R5: When the second upper word differs from the first, the block discards the whole attempt and starts again with an upper-half read. It issues exactly three reads per attempt and none after completion.
- R6: After `BUDGET` attempts have all failed (default 1000), `done` and `timed_out` pulse together and `value` is zero.
- R7: `done` is high for exactly one cycle per accepted start. It rises on the cycle after the clock edge that samples the final response, and `busy` is low from that cycle on.
- R8: A `start` pulse while `busy` is high is ignored. It changes neither the addresses in use nor the number of completions.
- R9: The attempt count restarts with every accepted start. Two back-to-back operations that each need `BUDGET` attempts both succeed.
- R10: A `rsp_vld` pulse while the block is idle has no effect. No `done` appears and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a fetch when idle |
| base_addr | input | ADDR_W | Address of the lower half; the upper half is at +4 |
| busy | output | 1 | A fetch is in progress |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Address of the current read |
| rsp_vld | input | 1 | Read data is valid this cycle |
| rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Qualifies `done`: the budget ran out |
| value | output | 64 | Assembled result, zero after a timeout |

## Verification
The bench's responder answers each request a random one to three cycles later and records the cycle of every response. The `done` pulse is due exactly one cycle after the final response: the response is sampled at the next edge and the pulse shows on the following falling edge. The bench checks `done` at that falling edge and then waits four more cycles to rule out a second pulse. A reference model inside the responder decides the expected result, address order and read count from the data it actually returned, including counters that carry between the halves. Requests are observed on falling edges, half a period away from the edge that changes them.

// File: rtl/tearfree_rd.sv
module tearfree_rd #(
  parameter int ADDR_W = 32,
  parameter int BUDGET = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_vld,
  input  logic [31:0]       rsp_data,
  output logic              done,
  output logic              timed_out,
  output logic [63:0]       value
);
  localparam int CNT_W = $clog2(BUDGET + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUDGET - 1);

  typedef enum logic [1:0] {IDLE, ISSUE, AWAIT} st_e;
  typedef enum logic [1:0] {P_HI1, P_LO, P_HI2} step_e;

  st_e               st;
  step_e             step;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       hi_q, lo_q;
  logic [CNT_W-1:0]  tries;

  assign busy    = (st != IDLE);
  assign rd_req  = (st == ISSUE);
  assign rd_addr = (step == P_LO) ? base_q : base_q + ADDR_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      step      <= P_HI1;
      base_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      tries     <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      value     <= '0;
    end else begin
      done      <= 1'b0;
      timed_out <= 1'b0;
      case (st)
        IDLE: if (start) begin
          base_q <= base_addr;
          tries  <= '0;
          step   <= P_HI1;
          st     <= ISSUE;
        end
        ISSUE: st <= AWAIT;
        AWAIT: if (rsp_vld) begin
          case (step)
            P_HI1: begin
              hi_q <= rsp_data;
              step <= P_LO;
              st   <= ISSUE;
            end
            P_LO: begin
              lo_q <= rsp_data;
              step <= P_HI2;
              st   <= ISSUE;
            end
            default: begin
              if (rsp_data == hi_q) begin
                value <= {hi_q, lo_q};
                done  <= 1'b1;
                st    <= IDLE;
              end else if (tries == LAST) begin
                value     <= '0;
                done      <= 1'b1;
                timed_out <= 1'b1;
                st        <= IDLE;
              end else begin
                tries <= tries + 1'b1;
                step  <= P_HI1;
                st    <= ISSUE;
              end
            end
          endcase
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tearfree_rd_chk.sv
module tearfree_rd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_req,
  input logic        rsp_vld,
  input logic        done,
  input logic        timed_out,
  input logic [63:0] value
);
  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       in_flight <= 1'b0;
    else if (rd_req)  in_flight <= 1'b1;
    else if (rsp_vld) in_flight <= 1'b0;
  end

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !rd_req);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  timeout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (done && value == 64'd0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
endmodule

bind tearfree_rd tearfree_rd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rsp_vld(rsp_vld),
  .done(done), .timed_out(timed_out), .value(value)
);

// File: tb/sim_tearfree_rd.sv
module sim_tearfree_rd;
  localparam int ADDR_W = 32;
  localparam int BUDGET = 1000;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        rsp_vld = 1'b0;
  logic [31:0] rsp_data = '0;
  wire         busy, rd_req, done, timed_out;
  wire  [31:0] rd_addr;
  wire  [63:0] value;

  always #10 clk = ~clk;

  tearfree_rd #(.ADDR_W(ADDR_W), .BUDGET(BUDGET)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
    .done(done), .timed_out(timed_out), .value(value));

  int checks = 0, fails = 0, tick = 0;
  logic [63:0] ctr;
  int step_min, step_max, flip_left, rd_idx, wait_cnt = 0, m_att;
  logic [31:0] held_addr, run_base, m_h1, m_lo;
  bit exp_final, exp_to, stray_req = 1'b0;
  logic [63:0] exp_val, cap_val;
  bit cap_to;
  int addr_err, late_reads, proto_err, last_rsp_t, done_cnt = 0, done_t;

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input int pos);
    return (pos == 1) ? b : b + 32'd4;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serve();
    int pos;
    logic [31:0] hi, lo, d;
    pos = rd_idx % 3;
    ctr = ctr + 64'(step_min + int'($urandom_range(step_max - step_min, 0)));
    hi = ctr[63:32];
    lo = ctr[31:0];
    if (pos == 2 && flip_left > 0) begin
      hi = hi ^ 32'h1;
      flip_left--;
    end
    if (held_addr != exp_addr(run_base, pos)) addr_err++;
    d = (pos == 1) ? lo : hi;
    if (exp_final) late_reads++;
    else if (pos == 0) m_h1 = d;
    else if (pos == 1) m_lo = d;
    else if (d == m_h1) begin
      exp_final = 1'b1; exp_val = {m_h1, m_lo}; exp_to = 1'b0;
    end else begin
      m_att++;
      if (m_att == BUDGET) begin
        exp_final = 1'b1; exp_val = '0; exp_to = 1'b1;
      end
    end
    rd_idx++;
    rsp_vld = 1'b1;
    rsp_data = d;
    last_rsp_t = tick;
  endtask

  always @(posedge clk) tick++;

  always @(negedge clk) begin
    if (rsp_vld) rsp_vld = 1'b0;
    if (wait_cnt > 0) begin
      if (rd_req) proto_err++;
      wait_cnt--;
      if (wait_cnt == 0) serve();
    end else if (rd_req) begin
      held_addr = rd_addr;
      wait_cnt = 1 + int'($urandom_range(2, 0));
    end else if (stray_req) begin
      rsp_vld = 1'b1;
      rsp_data = $urandom;
      stray_req = 1'b0;
    end
  end

  always @(negedge clk) if (done) begin
    done_cnt++;
    done_t = tick;
    cap_val = value;
    cap_to = timed_out;
  end

  always @(posedge clk) if (tick > 190000) begin
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<190000", tick);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic run(input logic [31:0] b, input logic [63:0] c0, input int smin, input int smax,
                     input int flips, input bit mid_start);
    @(negedge clk);
    run_base = b; ctr = c0; step_min = smin; step_max = smax; flip_left = flips;
    rd_idx = 0; m_att = 0; exp_final = 1'b0; exp_val = '0; exp_to = 1'b0;
    addr_err = 0; late_reads = 0; proto_err = 0; done_cnt = 0;
    base_addr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base_addr = $urandom;
    if (mid_start) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R8 busy before second start", 64'(busy), 64'd1);
      base_addr = b ^ 32'h100; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 20 * BUDGET && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, mid_start ? "R8 one completion" : "R7 one completion", 64'(done_cnt), 64'd1);
    chk(cap_to == exp_to, exp_to ? "R6 timeout flag" : "R4 no timeout", 64'(cap_to), 64'(exp_to));
    chk(cap_val == exp_val, exp_to ? "R6 zero result" : "R4 assembled value", cap_val, exp_val);
    chk(addr_err == 0, mid_start ? "R8 address unchanged" : "R2 address order", 64'(addr_err), 64'd0);
    chk(late_reads == 0 && rd_idx == 3 * (m_att + (exp_to ? 0 : 1)), "R5 read count",
        64'(rd_idx), 64'(3 * (m_att + (exp_to ? 0 : 1))));
    chk(done_t == last_rsp_t + 1, "R7 done latency", 64'(done_t), 64'(last_rsp_t + 1));
    chk(proto_err == 0, "R3 single outstanding", 64'(proto_err), 64'd0);
    chk(busy == 1'b0, "R7 idle after done", 64'(busy), 64'd0);
    chk(value == exp_val, "R4 value held", value, exp_val);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !done && !timed_out && value == 64'd0, "R1 in reset",
        {busy, rd_req, done, timed_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req && !done && !timed_out && value == 64'd0, "R1 after reset",
        {busy, rd_req, done, timed_out}, 64'd0);

    done_cnt = 0; stray_req = 1'b1;
    repeat (6) @(negedge clk);
    chk(done_cnt == 0 && !busy, "R10 stray response ignored", 64'(done_cnt), 64'd0);

    run(32'h0000_1000, 64'h0000_0012_3456_789A, 0, 0, 0, 1'b0);
    run(32'h0000_2008, 64'h0000_0005_FFFF_FFFE, 1, 1, 0, 1'b0);
    run(32'hFFFF_FFF8, 64'hDEAD_BEEF_0000_0001, 0, 0, 2, 1'b0);
    run(32'h0000_3000, 64'h0000_0777_0000_0010, 0, 2, 1, 1'b1);
    run(32'h0000_4000, 64'h0000_0042_0000_0000, 0, 0, BUDGET, 1'b0);
    run(32'h0000_5000, 64'h0000_0099_0000_0055, 0, 0, BUDGET - 1, 1'b0);
    chk(m_att == BUDGET - 1 && !cap_to, "R9 first full-budget run", 64'(m_att), 64'(BUDGET - 1));
    run(32'h0000_5000, 64'h0000_0099_0000_0077, 0, 0, BUDGET - 1, 1'b0);
    chk(m_att == BUDGET - 1 && !cap_to, "R9 second full-budget run", 64'(m_att), 64'(BUDGET - 1));

    for (int k = 0; k < 25; k++) begin
      logic [31:0] lo0;
      lo0 = ($urandom_range(1, 0) == 1) ? 32'hFFFF_FFF0 + 32'($urandom_range(15, 0)) : $urandom;
      run($urandom & 32'hFFFF_FFF8, {$urandom, lo0}, 0, int'($urandom_range(8, 0)),
          int'($urandom_range(2, 0)), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule